// File: doc/BRIEF.md
# Flash Erase Sequencer With Blank Skip

This block erases a byte range of a serial NOR flash. It accepts a start offset and a length. It splits the range into steps, and each step is either a 4 KiB sector erase or a 64 KiB block erase. It issues each step as a command on an abstract SPI transaction port. The layer that shifts bits on the wire sits below that port and is not part of this block.

Before each real erase, the sequencer polls the device status until the busy bit clears. It then sets the write-enable latch and reads status back to confirm the latch is set. Only then does it send the erase command, with a three-byte or four-byte address. In blank-skip mode it first reads the step's region back in bounded chunks. If every 32-bit word in the region is all ones, it skips the erase. After the final step it polls the device once more, then reports completion.

Each transaction on the port carries an opcode, an address, a command length in bytes and a read length. The device answers with zero or more read words on `rx_valid`/`rx_data`, followed by a one-cycle `txn_done`. The busy poll uses a programmable number of idle cycles between reads. It also has a deadline, counted in pulses of an external tick.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose offset or size is not a multiple of 4096, or whose size is below 4096, issues no transaction. It ends one cycle after acceptance with `done` high and `err_code` = 1.
- R2: With block mode on, a step uses the 64 KiB erase (opcode 0xD8) when the current offset is a multiple of 65536 and at least 65536 bytes remain. In every other case the step uses the 4 KiB erase (opcode 0x20). Each step advances the offset by its own size.
- R3: In blank-skip mode, each step's region is first read with opcode 0x03, in chunks of at most MAX_RD bytes. If every returned 32-bit word equals 0xFFFFFFFF, no erase is sent for that step. Any other word causes the erase to be sent.
- R4: Each erase is preceded by a write enable (opcode 0x06) and then a status read (opcode 0x05). In the status byte, bit 1 is the write-enable latch. If that bit is clear, the run ends with `err_code` = 3.
- R5: A read or erase command carries the full 32-bit address with command length 5 in four-byte mode. In three-byte mode it carries the low 24 address bits with command length 4. Status reads and write enables have command length 1.
- R6: Status is polled (status byte bit 0 = busy) until the device is idle before each erase and once more after the last step. `done` with `err_code` = 0 appears only after an idle status result.
- R7: If a status read still returns busy after `dl_limit` pulses of `dl_tick` have been counted in the current wait, the run ends with `err_code` = 2.
- R8: After a busy status result, the next status read is requested no sooner than `poll_gap` + 1 cycles later.
- R9: Any error ends the run at once: no further transaction is requested, and `busy` is low alongside `done`.
- R10: After reset, `busy`, `done` and `txn_valid` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a run (taken only while idle) |
| req_offset | input | 32 | First byte of the range |
| req_size | input | 32 | Length of the range in bytes |
| req_addr4 | input | 1 | Four-byte addressing |
| req_block_en | input | 1 | Allow 64 KiB erases |
| req_blank_skip | input | 1 | Read back and skip blank regions |
| poll_gap | input | CNT_W | Idle cycles between busy polls |
| dl_limit | input | CNT_W | Deadline in tick pulses |
| dl_tick | input | 1 | Deadline time base pulse |
| txn_valid | output | 1 | Transaction request |
| txn_ready | input | 1 | Transaction accepted |
| txn_opcode | output | 8 | Command opcode |
| txn_addr | output | 32 | Address (high byte zero in three-byte mode) |
| txn_cmd_len | output | 3 | Command bytes including address |
| txn_rd_len | output | RLW | Bytes to read back |
| rx_valid | input | 1 | Read word valid |
| rx_data | input | 32 | Read word (status in bits 1:0) |
| txn_done | input | 1 | Transaction finished |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 bad request, 2 timeout, 3 latch not set |

## Verification
A wrong step choice or a wrong address shows up at the very next erase command. It appears as an opcode, address or command length that differs from the queue of erases expected for the range. A flaw in the blank check shows up as an erase that is missing or extra within one step. Faults in poll sequencing show up as an erase issued, or `done` raised, while the modelled device is still busy. They can also show up as a shortened gap between polls, or as an error code on the same run. An abort that fails to stop would show up as a transaction after `done`.

// File: rtl/fe_pkg.sv
package fe_pkg;

  localparam logic [31:0] FE_SECTOR = 32'h0000_1000;
  localparam logic [31:0] FE_BLOCK  = 32'h0001_0000;

  typedef enum logic [1:0] {
    FE_OK      = 2'd0,
    FE_BAD_REQ = 2'd1,
    FE_TIMEOUT = 2'd2,
    FE_NO_WEL  = 2'd3
  } fe_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_CHK_REQ, S_CHK_WAIT, S_POLL_REQ, S_POLL_WAIT, S_GAP,
    S_WREN_REQ, S_WREN_WAIT, S_WEL_REQ, S_WEL_WAIT, S_ERASE_REQ,
    S_ERASE_WAIT, S_NEXT
  } fe_state_e;

  function automatic logic fe_req_ok(input logic [31:0] off, input logic [31:0] len);
    return (off[11:0] == 12'd0) && (len[11:0] == 12'd0) && (len >= FE_SECTOR);
  endfunction

  function automatic logic fe_pick_block(input logic en, input logic [31:0] off,
                                         input logic [31:0] rem);
    return en && (off[15:0] == 16'd0) && (rem >= FE_BLOCK);
  endfunction

  function automatic logic [31:0] fe_wire_addr(input logic [31:0] a, input logic four);
    return four ? a : {8'h00, a[23:0]};
  endfunction

  function automatic logic [2:0] fe_cmd_len(input logic four);
    return four ? 3'd5 : 3'd4;
  endfunction

endpackage

// File: rtl/fe_step_plan.sv
module fe_step_plan
  import fe_pkg::*;
(
  input  logic [31:0] cur_off,
  input  logic [31:0] remain,
  input  logic        blk_en,
  output logic        is_block,
  output logic [31:0] step_len
);
  always_comb begin
    is_block = fe_pick_block(blk_en, cur_off, remain);
    step_len = is_block ? FE_BLOCK : FE_SECTOR;
  end
endmodule

// File: rtl/fe_blank_scan.sv
module fe_blank_scan #(
  parameter int MAX_RD = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic [31:0] start_len,
  input  logic        adv,
  input  logic        word_en,
  input  logic [31:0] word,
  output logic [31:0] chunk_addr,
  output logic [31:0] chunk_len,
  output logic        last_chunk,
  output logic        dirty
);
  localparam logic [31:0] CHUNK = 32'(MAX_RD);

  logic [31:0] left_q;

  assign chunk_len  = (left_q > CHUNK) ? CHUNK : left_q;
  assign last_chunk = (left_q <= CHUNK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_addr <= '0;
      left_q     <= '0;
      dirty      <= 1'b0;
    end else if (start) begin
      chunk_addr <= start_addr;
      left_q     <= start_len;
      dirty      <= 1'b0;
    end else begin
      if (word_en && (word != 32'hFFFF_FFFF)) dirty <= 1'b1;
      if (adv) begin
        chunk_addr <= chunk_addr + chunk_len;
        left_q     <= left_q - chunk_len;
      end
    end
  end

  // R3: any non-blank word marks the region for erase
  a_r3_mismatch_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (word_en && !start && word != 32'hFFFF_FFFF) |=> dirty);
endmodule

// File: rtl/fe_poll_timer.sv
module fe_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             gap_start,
  input  logic [CNT_W-1:0] gap_len,
  output logic             gap_done,
  output logic             dl_hit
);
  logic [CNT_W-1:0] dl_cnt, gap_cnt;

  assign gap_done = (gap_cnt == '0);
  assign dl_hit   = (dl_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_cnt  <= '0;
      gap_cnt <= '0;
    end else begin
      if (arm) dl_cnt <= '0;
      else if (tick && (dl_cnt != '1)) dl_cnt <= dl_cnt + 1'b1;
      if (gap_start) gap_cnt <= gap_len;
      else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
    end
  end

  // R7: the deadline count only grows within one wait
  a_r7_deadline_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> dl_cnt >= $past(dl_cnt));
  // R8: the gap counter starts from the programmed interval
  a_r8_gap_load: assert property (@(posedge clk) disable iff (!rst_n)
    gap_start |=> gap_cnt == $past(gap_len));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fe_pkg::*;
#(
  parameter int          MAX_RD  = 256,
  parameter int          CNT_W   = 16,
  parameter logic [7:0]  OP_RDSR = 8'h05,
  parameter logic [7:0]  OP_WREN = 8'h06,
  parameter logic [7:0]  OP_READ = 8'h03,
  parameter logic [7:0]  OP_SE   = 8'h20,
  parameter logic [7:0]  OP_BE   = 8'hD8,
  localparam int         RLW     = $clog2(MAX_RD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_offset,
  input  logic [31:0]      req_size,
  input  logic             req_addr4,
  input  logic             req_block_en,
  input  logic             req_blank_skip,
  input  logic [CNT_W-1:0] poll_gap,
  input  logic [CNT_W-1:0] dl_limit,
  input  logic             dl_tick,
  output logic             txn_valid,
  input  logic             txn_ready,
  output logic [7:0]       txn_opcode,
  output logic [31:0]      txn_addr,
  output logic [2:0]       txn_cmd_len,
  output logic [RLW-1:0]   txn_rd_len,
  input  logic             rx_valid,
  input  logic [31:0]      rx_data,
  input  logic             txn_done,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code
);
  fe_state_e   st;
  fe_err_e     err_q;
  logic        done_q;
  logic [31:0] cur_off, remain, step_len_q;
  logic        addr4_q, blk_q, skip_q, final_q;
  logic [1:0]  stat_q;

  logic        plan_blk;
  logic [31:0] plan_len;
  logic [31:0] scan_addr, scan_len;
  logic        scan_last, scan_dirty;
  logic        gap_done, dl_hit;

  // named internal events
  logic scan_start, scan_adv, word_en, last_step, wait_arm, gap_start;
  assign scan_start = (st == S_PLAN) && skip_q;
  assign scan_adv   = (st == S_CHK_WAIT) && txn_done;
  assign word_en    = (st == S_CHK_WAIT) && rx_valid;
  assign last_step  = (remain == step_len_q);
  assign wait_arm   = ((st == S_PLAN) && !skip_q) || (scan_adv && scan_dirty) ||
                      ((st == S_NEXT) && last_step);
  assign gap_start  = (st == S_POLL_WAIT) && txn_done && stat_q[0] && !dl_hit;

  fe_step_plan u_plan (
    .cur_off (cur_off), .remain (remain), .blk_en (blk_q),
    .is_block(plan_blk), .step_len (plan_len)
  );

  fe_blank_scan #(.MAX_RD(MAX_RD)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(scan_start), .start_addr(cur_off),
    .start_len(plan_len), .adv(scan_adv), .word_en(word_en), .word(rx_data),
    .chunk_addr(scan_addr), .chunk_len(scan_len), .last_chunk(scan_last),
    .dirty(scan_dirty)
  );

  fe_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(wait_arm), .tick(dl_tick), .limit(dl_limit),
    .gap_start(gap_start), .gap_len(poll_gap), .gap_done(gap_done), .dl_hit(dl_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      err_q      <= FE_OK;
      done_q     <= 1'b0;
      cur_off    <= '0;
      remain     <= '0;
      step_len_q <= '0;
      addr4_q    <= 1'b0;
      blk_q      <= 1'b0;
      skip_q     <= 1'b0;
      final_q    <= 1'b0;
      stat_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (rx_valid && (st == S_POLL_WAIT || st == S_WEL_WAIT)) stat_q <= rx_data[1:0];
      case (st)
        S_IDLE: if (req_valid) begin
          cur_off <= req_offset;
          remain  <= req_size;
          addr4_q <= req_addr4;
          blk_q   <= req_block_en;
          skip_q  <= req_blank_skip;
          final_q <= 1'b0;
          err_q   <= FE_OK;
          if (fe_req_ok(req_offset, req_size)) st <= S_PLAN;
          else begin
            err_q  <= FE_BAD_REQ;
            done_q <= 1'b1;
          end
        end
        S_PLAN: begin
          step_len_q <= plan_len;
          st <= skip_q ? S_CHK_REQ : S_POLL_REQ;
        end
        S_CHK_REQ:  if (txn_ready) st <= S_CHK_WAIT;
        S_CHK_WAIT: if (txn_done) begin
          if (scan_dirty)     st <= S_POLL_REQ;
          else if (scan_last) st <= S_NEXT;
          else                st <= S_CHK_REQ;
        end
        S_POLL_REQ:  if (txn_ready) st <= S_POLL_WAIT;
        S_POLL_WAIT: if (txn_done) begin
          if (!stat_q[0]) begin
            if (final_q) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else st <= S_WREN_REQ;
          end else if (dl_hit) begin
            err_q  <= FE_TIMEOUT;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else st <= S_GAP;
        end
        S_GAP:       if (gap_done) st <= S_POLL_REQ;
        S_WREN_REQ:  if (txn_ready) st <= S_WREN_WAIT;
        S_WREN_WAIT: if (txn_done) st <= S_WEL_REQ;
        S_WEL_REQ:   if (txn_ready) st <= S_WEL_WAIT;
        S_WEL_WAIT:  if (txn_done) begin
          if (stat_q[1]) st <= S_ERASE_REQ;
          else begin
            err_q  <= FE_NO_WEL;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_ERASE_REQ:  if (txn_ready) st <= S_ERASE_WAIT;
        S_ERASE_WAIT: if (txn_done) st <= S_NEXT;
        S_NEXT: begin
          cur_off <= cur_off + step_len_q;
          remain  <= remain - step_len_q;
          if (last_step) begin
            final_q <= 1'b1;
            st      <= S_POLL_REQ;
          end else st <= S_PLAN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    txn_valid   = 1'b0;
    txn_opcode  = 8'h00;
    txn_addr    = '0;
    txn_cmd_len = 3'd0;
    txn_rd_len  = '0;
    case (st)
      S_CHK_REQ: begin
        txn_valid   = 1'b1;
        txn_opcode  = OP_READ;
        txn_addr    = fe_wire_addr(scan_addr, addr4_q);
        txn_cmd_len = fe_cmd_len(addr4_q);
        txn_rd_len  = RLW'(scan_len);
      end
      S_POLL_REQ, S_WEL_REQ: begin
        txn_valid   = 1'b1;
        txn_opcode  = OP_RDSR;
        txn_cmd_len = 3'd1;
        txn_rd_len  = RLW'(1);
      end
      S_WREN_REQ: begin
        txn_valid   = 1'b1;
        txn_opcode  = OP_WREN;
        txn_cmd_len = 3'd1;
      end
      S_ERASE_REQ: begin
        txn_valid   = 1'b1;
        txn_opcode  = (step_len_q == FE_BLOCK) ? OP_BE : OP_SE;
        txn_addr    = fe_wire_addr(cur_off, addr4_q);
        txn_cmd_len = fe_cmd_len(addr4_q);
      end
      default: ;
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err_code = err_q;

  // R1: malformed requests end at once with the bad-request code
  a_r1_bad_req: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid &&
     (req_offset[11:0] != 12'd0 || req_size[11:0] != 12'd0 || req_size < 32'd4096))
    |=> (done && err_code == FE_BAD_REQ && !txn_valid));
  // R2: a block erase starts on a 64 KiB boundary with a full block left
  a_r2_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_opcode == OP_BE) |-> (txn_addr[15:0] == 16'd0 && remain >= FE_BLOCK));
  // R4: an erase request follows a status read that showed the latch set
  a_r4_erase_after_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE_REQ && $past(st) != S_ERASE_REQ) |-> ($past(st) == S_WEL_WAIT && $past(stat_q[1])));
  // R5: three-byte mode never puts a high address byte on the port
  a_r5_three_byte_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !addr4_q && txn_cmd_len != 3'd1) |-> (txn_addr[31:24] == 8'h00 && txn_cmd_len == 3'd4));
  // R6: a clean finish comes only from an idle status result
  a_r6_done_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == FE_OK) |-> ($past(st) == S_POLL_WAIT && !$past(stat_q[0])));
  // R9: an error leaves the port quiet
  a_r9_stop_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != FE_OK) |-> (!txn_valid && !busy));
endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int MAX_RD = 256;
  localparam int CNT_W  = 16;
  localparam int RLW    = $clog2(MAX_RD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_addr4 = 1'b0, req_block_en = 1'b0, req_blank_skip = 1'b0;
  logic [31:0] req_offset = '0, req_size = '0;
  logic [CNT_W-1:0] poll_gap = 16'd3, dl_limit = 16'd50;
  logic dl_tick = 1'b0, txn_ready = 1'b0, rx_valid = 1'b0, txn_done = 1'b0;
  logic [31:0] rx_data = '0;
  logic txn_valid, busy, done;
  logic [7:0] txn_opcode;
  logic [31:0] txn_addr;
  logic [2:0] txn_cmd_len;
  logic [RLW-1:0] txn_rd_len;
  logic [1:0] err_code;

  flash_erase_seq #(.MAX_RD(MAX_RD), .CNT_W(CNT_W)) i_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_size(req_size), .req_addr4(req_addr4), .req_block_en(req_block_en),
    .req_blank_skip(req_blank_skip), .poll_gap(poll_gap), .dl_limit(dl_limit),
    .dl_tick(dl_tick), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_opcode(txn_opcode), .txn_addr(txn_addr), .txn_cmd_len(txn_cmd_len),
    .txn_rd_len(txn_rd_len), .rx_valid(rx_valid), .rx_data(rx_data),
    .txn_done(txn_done), .busy(busy), .done(done), .err_code(err_code)
  );

  always #10 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0, txn_cnt = 0;
  initial forever begin @(posedge clk); cyc++; end

  // device model state
  logic [63:0] dirty_sec = '0;
  bit wel = 0, stuck = 0, no_wel = 0;
  int busy_left = 0, busy_polls = 2, prev_busy_end = -1;

  typedef struct packed { logic [7:0] op; logic [31:0] addr; logic [2:0] cl; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    repeat (7) @(negedge clk);
    dl_tick = 1'b1;
    @(negedge clk);
    dl_tick = 1'b0;
  end

  // transaction responder and scoreboard monitor
  initial begin
    logic [7:0] op; logic [31:0] ad; logic [2:0] cl; int rl; bit bsy; exp_t e;
    forever begin
      @(negedge clk);
      if (txn_valid) begin
        op = txn_opcode; ad = txn_addr; cl = txn_cmd_len; rl = int'(txn_rd_len);
        txn_cnt++;
        txn_ready = 1'b1;
        if (op == 8'h05 && prev_busy_end >= 0) begin
          chk(cyc - prev_busy_end >= int'(poll_gap) + 1, "R8", "poll spacing",
              cyc - prev_busy_end, int'(poll_gap) + 1);
          prev_busy_end = -1;
        end
        @(negedge clk);
        txn_ready = 1'b0;
        case (op)
          8'h05: begin
            chk(cl == 3'd1, "R5", "status cmd len", cl, 1);
            bsy = stuck || (busy_left > 0);
            if (busy_left > 0) busy_left--;
            rx_valid = 1'b1; rx_data = {30'd0, wel, bsy};
            @(negedge clk);
            rx_valid = 1'b0;
          end
          8'h06: wel = !no_wel;
          8'h03: begin
            for (int w = 0; w < rl / 4; w++) begin
              logic [31:0] wa;
              wa = ad + 32'(4 * w);
              rx_valid = 1'b1;
              rx_data = (dirty_sec[wa[17:12]] && wa[11:2] == 10'h3FF) ? 32'h0 : 32'hFFFF_FFFF;
              @(negedge clk);
            end
            rx_valid = 1'b0;
          end
          default: begin
            chk(wel, "R4", "latch before erase", {31'd0, wel}, 1);
            chk(busy_left == 0 && !stuck, "R6", "device idle at erase", busy_left, 0);
            if (q.size() == 0) chk(0, "R2", "unexpected erase at", ad, 0);
            else begin
              e = q.pop_front();
              chk(op == e.op, "R2", "erase opcode", op, e.op);
              chk(ad == e.addr, "R5", "erase address", ad, e.addr);
              chk(cl == e.cl, "R5", "erase cmd len", cl, e.cl);
            end
            wel = 0;
            busy_left = busy_polls;
          end
        endcase
        txn_done = 1'b1;
        if (op == 8'h05 && (stuck || rx_data[0])) prev_busy_end = cyc;
        @(negedge clk);
        txn_done = 1'b0;
      end
    end
  end

  // driver: computes the expected erase list from the requirements
  task automatic expect_plan(input logic [31:0] off, input logic [31:0] sz,
                             input bit a4, input bit blk, input bit skp);
    logic [31:0] o, s, len, sa;
    bit clean;
    exp_t e;
    o = off; s = sz;
    while (s > 0) begin
      len = (blk && (o % 65536 == 0) && s >= 65536) ? 32'd65536 : 32'd4096;
      clean = skp;
      for (logic [31:0] k = 0; k < len; k += 4096) begin
        sa = o + k;
        if (dirty_sec[sa[17:12]]) clean = 0;
      end
      if (!clean) begin
        e.op = (len == 65536) ? 8'hD8 : 8'h20;
        e.addr = a4 ? o : (o & 32'h00FF_FFFF);
        e.cl = a4 ? 3'd5 : 3'd4;
        q.push_back(e);
      end
      o += len; s -= len;
    end
  endtask

  task automatic run(input logic [31:0] off, input logic [31:0] sz, input bit a4,
                     input bit blk, input bit skp, input logic [1:0] exp_err,
                     input bit plan, input string req);
    int guard, seen;
    if (plan) expect_plan(off, sz, a4, blk, skp);
    @(negedge clk);
    req_offset = off; req_size = sz; req_addr4 = a4;
    req_block_en = blk; req_blank_skip = skp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 60000) begin @(negedge clk); guard++; end
    chk(done, req, "run completes", {31'd0, done}, 1);
    chk(err_code == exp_err, req, "error code", err_code, exp_err);
    chk(q.size() == 0, req, "erases left unissued", q.size(), 0);
    if (exp_err == 2'd0) chk(busy_left == 0, "R6", "device idle at done", busy_left, 0);
    else chk(!busy, "R9", "idle with error", {31'd0, busy}, 0);
    seen = txn_cnt;
    repeat (20) @(negedge clk);
    chk(txn_cnt == seen, "R9", "no transaction after done", txn_cnt, seen);
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !txn_valid && err_code == 2'd0, "R10", "reset state",
        {busy, done, txn_valid, err_code}, 0);

    // R1 malformed requests
    run(32'h1001, 32'h1000, 0, 0, 0, 2'd1, 0, "R1");
    run(32'h0,    32'h0,    0, 0, 0, 2'd1, 0, "R1");
    run(32'h0,    32'h800,  0, 0, 0, 2'd1, 0, "R1");
    run(32'h2000, 32'h1800, 0, 1, 0, 2'd1, 0, "R1");
    // R2 / R5 granularity and framing
    run(32'h2000,  32'h2000,  0, 0, 0, 2'd0, 1, "R2");
    run(32'hF000,  32'h12000, 0, 1, 0, 2'd0, 1, "R2");
    run(32'h10000, 32'hF000,  0, 1, 0, 2'd0, 1, "R2");
    run(32'h0100_2000, 32'h1000, 1, 0, 0, 2'd0, 1, "R5");
    run(32'h0100_3000, 32'h1000, 0, 0, 0, 2'd0, 1, "R5");
    // R3 blank skip
    dirty_sec = 64'h2;
    run(32'h0, 32'h4000, 0, 0, 1, 2'd0, 1, "R3");
    dirty_sec = '0;
    run(32'h0, 32'h3000, 0, 0, 1, 2'd0, 1, "R3");
    dirty_sec = 64'h1 << 31;
    run(32'h10000, 32'h10000, 1, 1, 1, 2'd0, 1, "R3");
    dirty_sec = '0;
    // R6 / R8 with longer busy phases and wider gap
    busy_polls = 4; poll_gap = 16'd6;
    run(32'h4000, 32'h2000, 0, 0, 0, 2'd0, 1, "R6");
    busy_polls = 2; poll_gap = 16'd3;
    // R7 timeout, R9 abort
    stuck = 1;
    run(32'h0, 32'h3000, 0, 0, 0, 2'd2, 0, "R7");
    stuck = 0; busy_left = 0;
    // R4 latch not set, R9 abort
    no_wel = 1;
    run(32'h0, 32'h3000, 0, 0, 0, 2'd3, 0, "R4");
    no_wel = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 180000);
    n_fail++;
    $display("FAIL R10 watchdog: actual %0d cycles expected fewer", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule